// File: doc/BRIEF.md
# Local/Remote DMA Bus Arbiter

This block is the control state machine of a network controller's bus master. It decides who owns the system bus between two DMA clients. The local client moves bytes between the packet FIFO and the buffer ring during receive or transmit. The remote client carries out buffer moves requested by the host. The block tracks a reset mode and an idle mode. It raises a bus request, waits for the grant and then issues one byte strobe per transferred byte. It also reports which client owns each strobe. Address generation and the electrical bus protocol belong to other blocks.

The local client has priority over the remote client. Each local transfer is a burst of a fixed, programmable number of bytes. A burst is only started when the FIFO asks for service and its fill level is strictly above a programmable threshold. The remote client has two cases:

- If the remote client is still waiting for the bus when the FIFO asks for service, the local burst goes first.
- If the remote client already holds the bus, the local burst is appended to its transfer without dropping the request.

In both cases the remote client keeps its remaining byte count. After the local burst it requests the bus again and finishes. A stop command, a hard reset input or any of three error flags returns the block to reset at once.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After `rst_n` is released, the block is in reset mode: `in_reset`=1, `bus_req`=0, `owner`=00 and `byte_strobe`=0. In reset mode, FIFO and remote requests raise no bus request, and a remote count offered then is not kept.
- R2: A `cmd_start` pulse in reset mode, with no abort condition present, clears `in_reset` at the next clock edge. The block is then idle.
- R3: A local burst produces exactly 2, 4, 8 or 12 strobes with `owner`=01, for `burst_sel` = 0, 1, 2 or 3 respectively. The burst runs to its end even if `fifo_req` is withdrawn after the request.
- R4: A local burst is requested only while `fifo_req`=1 and `fifo_level` > `fifo_thresh`. A level equal to the threshold starts nothing.
- R5: `rmt_req` with a nonzero `rmt_count` loads the remote count when no remote transfer is pending. A request made while a count is pending is ignored. The transfer produces exactly that many strobes with `owner`=10 and then releases the bus.
- R6: A local request takes priority over a remote transfer that has not yet received the grant. The local burst runs first and the remote transfer then completes with its full count.
- R7: A local request seen during a remote strobe cycle (not the last one) starts the local burst in the next cycle. `bus_req` stays high across the change. After the burst, `bus_req` drops for exactly one cycle. The remote transfer then requests the bus again and delivers its remaining bytes.
- R8: Any of `cmd_stop`, `hard_rst`, `err_fifo_under`, `err_fifo_over` or `err_ring_over` forces `byte_strobe`=0 and `bus_req`=0 in the same cycle. It sets `in_reset`=1 at the next edge and discards any pending remote count.
- R9: `owner` is never 11. A strobe occurs only with a nonzero owner. No strobe occurs while a request waits for `bus_grant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_start | input | 1 | Start command: leave reset mode for idle |
| cmd_stop | input | 1 | Stop command: return to reset mode |
| hard_rst | input | 1 | Synchronous hard reset request |
| err_fifo_under | input | 1 | FIFO underflow error |
| err_fifo_over | input | 1 | FIFO overflow error |
| err_ring_over | input | 1 | Receive buffer ring overflow error |
| burst_sel | input | 2 | Local burst length: 0=2, 1=4, 2=8, 3=12 bytes |
| fifo_req | input | 1 | FIFO service request |
| fifo_level | input | LVL_W | FIFO fill level |
| fifo_thresh | input | LVL_W | Fill level that must be exceeded to start a burst |
| rmt_req | input | 1 | Remote transfer request |
| rmt_count | input | CNT_W | Byte count of the remote transfer, taken with `rmt_req` |
| bus_grant | input | 1 | Bus grant |
| bus_req | output | 1 | Bus request |
| owner | output | 2 | Owner of the current strobe: 00 none, 01 local, 10 remote |
| byte_strobe | output | 1 | One pulse per transferred byte |
| in_reset | output | 1 | High in reset mode |

## Verification
The bench sweeps every burst length through plain bursts, preemption of a waiting remote transfer, and bursts appended to a running one.

- A counter loaded off by one would give a wrong strobe total for some length.
- An arbiter that resets the remote count on preemption would deliver fewer remote bytes than were requested.
- A design that drops the bus before an appended burst would show an extra gap in the logged request trace.
- A design that keeps the bus after a local burst would show no gap at all.

Thresholds are tried at equality and one above. This catches a comparison written as greater-or-equal. Each of the five abort sources is applied in the middle of a remote transfer. The bench checks that no strobe appears in that cycle and that the pending count does not resume after restart.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_IDLE  = 3'd1,
    ST_LREQ  = 3'd2,
    ST_LXFER = 3'd3,
    ST_RREQ  = 3'd4,
    ST_RXFER = 3'd5
  } arb_state_t;

  localparam logic [1:0] OWN_NONE   = 2'b00;
  localparam logic [1:0] OWN_LOCAL  = 2'b01;
  localparam logic [1:0] OWN_REMOTE = 2'b10;

  localparam int BURST_W = 4;

  // Burst length selected by the 2-bit configuration field.
  function automatic logic [BURST_W-1:0] burst_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return BURST_W'(2);
      2'd1:    return BURST_W'(4);
      2'd2:    return BURST_W'(8);
      default: return BURST_W'(12);
    endcase
  endfunction

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dma_burst_ctr.sv
module dma_burst_ctr #(
  parameter int W = dma_arb_pkg::BURST_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] len,
  input  logic         dec,
  output logic         last
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                         cnt_d = '0;
    else if (load)                   cnt_d = len;
    else if (dec && cnt_q != '0)     cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == W'(1));

endmodule

// File: rtl/dma_rmt_ctr.sv
module dma_rmt_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         pending,
  output logic         last
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                         cnt_d = '0;
    else if (load)                   cnt_d = load_val;
    else if (dec && cnt_q != '0)     cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pending = (cnt_q != '0);
  assign last    = (cnt_q == W'(1));

endmodule

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       cmd_start,
  input  logic       local_go,
  input  logic       rmt_pending,
  input  logic       rmt_last,
  input  logic       burst_last,
  input  logic       bus_grant,
  output arb_state_t state,
  output logic       burst_load,
  output logic       burst_dec,
  output logic       rmt_dec
);

  arb_state_t st_q, st_d;

  always_comb begin
    st_d       = st_q;
    burst_load = 1'b0;
    burst_dec  = 1'b0;
    rmt_dec    = 1'b0;
    if (abort) begin
      st_d = ST_RESET;
    end else begin
      unique case (st_q)
        ST_RESET: if (cmd_start) st_d = ST_IDLE;
        ST_IDLE: begin
          if (local_go)         st_d = ST_LREQ;
          else if (rmt_pending) st_d = ST_RREQ;
        end
        ST_LREQ: begin
          if (bus_grant) begin
            st_d       = ST_LXFER;
            burst_load = 1'b1;
          end
        end
        ST_LXFER: begin
          burst_dec = 1'b1;
          if (burst_last) st_d = ST_IDLE;
        end
        ST_RREQ: begin
          if (local_go)       st_d = ST_LREQ;
          else if (bus_grant) st_d = ST_RXFER;
        end
        ST_RXFER: begin
          rmt_dec = 1'b1;
          if (rmt_last) begin
            st_d = ST_IDLE;
          end else if (local_go) begin
            st_d       = ST_LXFER;
            burst_load = 1'b1;
          end
        end
        default: st_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RESET;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             hard_rst,
  input  logic             err_fifo_under,
  input  logic             err_fifo_over,
  input  logic             err_ring_over,
  input  logic [1:0]       burst_sel,
  input  logic             fifo_req,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] fifo_thresh,
  input  logic             rmt_req,
  input  logic [CNT_W-1:0] rmt_count,
  input  logic             bus_grant,
  output logic             bus_req,
  output logic [1:0]       owner,
  output logic             byte_strobe,
  output logic             in_reset
);

  logic       rst_sync_n;
  logic       abort_now;
  logic       local_go;
  logic       rmt_pending, rmt_last, rmt_load, rmt_clr, rmt_dec;
  logic       burst_last, burst_load, burst_dec;
  arb_state_t state;

  dma_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign abort_now = cmd_stop | hard_rst | err_fifo_under | err_fifo_over | err_ring_over;
  assign local_go  = fifo_req && (fifo_level > fifo_thresh);

  assign rmt_clr  = abort_now || (state == ST_RESET);
  assign rmt_load = rmt_req && !rmt_pending && (rmt_count != '0);

  dma_arb_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .abort       (abort_now),
    .cmd_start   (cmd_start),
    .local_go    (local_go),
    .rmt_pending (rmt_pending),
    .rmt_last    (rmt_last),
    .burst_last  (burst_last),
    .bus_grant   (bus_grant),
    .state       (state),
    .burst_load  (burst_load),
    .burst_dec   (burst_dec),
    .rmt_dec     (rmt_dec)
  );

  dma_burst_ctr #(.W(BURST_W)) u_burst (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (abort_now),
    .load  (burst_load),
    .len   (burst_len(burst_sel)),
    .dec   (burst_dec),
    .last  (burst_last)
  );

  dma_rmt_ctr #(.W(CNT_W)) u_rmt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (rmt_clr),
    .load     (rmt_load),
    .load_val (rmt_count),
    .dec      (rmt_dec),
    .pending  (rmt_pending),
    .last     (rmt_last)
  );

  always_comb begin
    bus_req     = 1'b0;
    owner       = OWN_NONE;
    byte_strobe = 1'b0;
    unique case (state)
      ST_LREQ, ST_RREQ: bus_req = !abort_now;
      ST_LXFER: begin
        bus_req     = !abort_now;
        byte_strobe = !abort_now;
        owner       = OWN_LOCAL;
      end
      ST_RXFER: begin
        bus_req     = !abort_now;
        byte_strobe = !abort_now;
        owner       = OWN_REMOTE;
      end
      default: ;
    endcase
  end

  assign in_reset = (state == ST_RESET);

endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk
  import dma_arb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       abort,
  input logic       cmd_start,
  input logic       in_reset,
  input logic       bus_req,
  input logic [1:0] owner,
  input logic       byte_strobe
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset |-> (!bus_req && owner == OWN_NONE && !byte_strobe));

  // R2
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_reset && cmd_start && !abort) |=> !in_reset);

  // R8
  abort_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!byte_strobe && !bus_req));

  // R8
  abort_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> in_reset);

  // R9
  owner_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner));

  // R9
  strobe_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_strobe |-> (owner != OWN_NONE));

  // R7
  release_after_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(owner) == OWN_LOCAL && owner != OWN_LOCAL) |-> !bus_req);

  // R7
  append_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(owner) == OWN_REMOTE && owner == OWN_LOCAL) |-> ($past(bus_req) && bus_req));

endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .abort       (abort_now),
  .cmd_start   (cmd_start),
  .in_reset    (in_reset),
  .bus_req     (bus_req),
  .owner       (owner),
  .byte_strobe (byte_strobe)
);

// File: tb/dma_bus_arbiter_test.sv
module dma_bus_arbiter_test;
  import dma_arb_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 5;
  localparam int CNT_W = 8;
  localparam int LOG_N = 128;

  logic clk, rst_n, cmd_start, cmd_stop, hard_rst;
  logic err_fifo_under, err_fifo_over, err_ring_over;
  logic [1:0] burst_sel;
  logic fifo_req, rmt_req, bus_grant, grant_en;
  logic [LVL_W-1:0] fifo_level, fifo_thresh;
  logic [CNT_W-1:0] rmt_count;
  logic bus_req, byte_strobe, in_reset;
  logic [1:0] owner;

  int checks = 0;
  int fails = 0;
  int loc_n, rmt_n, viol_n;
  logic [1:0] first_own;
  logic log_en;
  int log_i;
  logic [1:0] own_log [0:LOG_N-1];
  logic breq_log [0:LOG_N-1];

  assign bus_grant = bus_req & grant_en;

  dma_bus_arbiter #(.LVL_W(LVL_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .hard_rst(hard_rst), .err_fifo_under(err_fifo_under), .err_fifo_over(err_fifo_over),
    .err_ring_over(err_ring_over), .burst_sel(burst_sel), .fifo_req(fifo_req),
    .fifo_level(fifo_level), .fifo_thresh(fifo_thresh), .rmt_req(rmt_req),
    .rmt_count(rmt_count), .bus_grant(bus_grant), .bus_req(bus_req), .owner(owner),
    .byte_strobe(byte_strobe), .in_reset(in_reset)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Strobe counting and trace logging on the values before each edge
  always @(posedge clk) begin
    if (byte_strobe) begin
      if (owner == 2'b01)      loc_n++;
      else if (owner == 2'b10) rmt_n++;
      else                     viol_n++;
      if (first_own == 2'b00) first_own = owner;
    end
    if (owner == 2'b11) viol_n++;
    if (log_en && log_i < LOG_N) begin
      own_log[log_i]  = owner;
      breq_log[log_i] = bus_req;
      log_i++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_cnt();
    loc_n = 0; rmt_n = 0; first_own = 2'b00;
  endtask

  function automatic int exp_len(input int sel);
    return (sel == 3) ? 12 : (2 << sel);
  endfunction

  task automatic start_cmd();
    @(negedge clk); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic pulse_fifo();
    @(negedge clk); fifo_req = 1'b1;
    @(negedge clk); fifo_req = 1'b0;
  endtask

  task automatic pulse_rmt(input int n);
    @(negedge clk); rmt_req = 1'b1; rmt_count = CNT_W'(n);
    @(negedge clk); rmt_req = 1'b0;
  endtask

  task automatic set_abort(input int k, input logic v);
    case (k)
      0: cmd_stop = v;
      1: hard_rst = v;
      2: err_fifo_under = v;
      3: err_fifo_over = v;
      default: err_ring_over = v;
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_start = 0; cmd_stop = 0; hard_rst = 0;
    err_fifo_under = 0; err_fifo_over = 0; err_ring_over = 0;
    burst_sel = 2'd0; fifo_req = 0; rmt_req = 0; grant_en = 1'b1;
    fifo_level = '0; fifo_thresh = '0; rmt_count = '0;
    viol_n = 0; log_en = 1'b0; log_i = 0;
    clr_cnt();
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    #1;
    // R1 reset state
    chk(in_reset == 1'b1, "R1 in_reset after reset", in_reset, 1);
    chk(bus_req == 1'b0 && byte_strobe == 1'b0, "R1 bus quiet after reset", bus_req, 0);
    chk(owner == 2'b00, "R1 owner after reset", owner, 0);

    // R1 requests ignored in reset mode
    fifo_thresh = 5'd3; fifo_level = 5'd20; fifo_req = 1'b1;
    rmt_req = 1'b1; rmt_count = 8'd7;
    clr_cnt();
    cyc(6); #1;
    chk(bus_req == 1'b0 && in_reset == 1'b1, "R1 no request in reset", bus_req, 0);
    fifo_req = 1'b0; rmt_req = 1'b0;

    // R2 start leaves reset at the next edge
    @(negedge clk); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0; #1;
    chk(in_reset == 1'b0, "R2 idle after start", in_reset, 0);
    cyc(20);
    chk(rmt_n == 0 && loc_n == 0, "R1 count from reset mode not kept", rmt_n, 0);

    // R3 burst length sweep
    for (int s = 0; s < 4; s++) begin
      burst_sel = 2'(s);
      clr_cnt();
      pulse_fifo();
      cyc(20); #1;
      chk(loc_n == exp_len(s), $sformatf("R3 burst length sel=%0d", s), loc_n, exp_len(s));
      chk(bus_req == 1'b0, "R3 bus released after burst", bus_req, 0);
    end

    // R4 threshold: equal starts nothing, one above starts a burst
    burst_sel = 2'd1;
    for (int t = 0; t < 4; t++) begin
      int thr;
      thr = (t == 0) ? 0 : (t == 1) ? 5 : (t == 2) ? 17 : 30;
      fifo_thresh = LVL_W'(thr);
      fifo_level = LVL_W'(thr);
      clr_cnt();
      @(negedge clk); fifo_req = 1'b1;
      cyc(10); fifo_req = 1'b0;
      cyc(5);
      chk(loc_n == 0, $sformatf("R4 level equal to thresh %0d", thr), loc_n, 0);
      fifo_level = LVL_W'(thr + 1);
      pulse_fifo();
      cyc(15);
      chk(loc_n == 4, $sformatf("R4 level above thresh %0d", thr), loc_n, 4);
    end
    fifo_thresh = 5'd3; fifo_level = 5'd20;

    // R5 remote transfer byte count
    for (int i = 0; i < 4; i++) begin
      int n;
      n = (i == 0) ? 1 : (i == 1) ? 2 : (i == 2) ? 7 : 255;
      clr_cnt();
      pulse_rmt(n);
      cyc(n + 10); #1;
      chk(rmt_n == n, $sformatf("R5 remote strobes n=%0d", n), rmt_n, n);
      chk(bus_req == 1'b0, "R5 bus released after remote", bus_req, 0);
    end
    // R5 second request while pending is ignored
    clr_cnt();
    pulse_rmt(10);
    cyc(3);
    pulse_rmt(50);
    cyc(30);
    chk(rmt_n == 10, "R5 request while pending ignored", rmt_n, 10);

    // R6 preemption of a remote transfer waiting for grant
    for (int s = 0; s < 4; s++) begin
      burst_sel = 2'(s);
      grant_en = 1'b0;
      clr_cnt();
      pulse_rmt(5);
      cyc(3); #1;
      chk(bus_req == 1'b1 && loc_n + rmt_n == 0, "R9 no strobe without grant", loc_n + rmt_n, 0);
      @(negedge clk); fifo_req = 1'b1;
      @(negedge clk); fifo_req = 1'b0; grant_en = 1'b1;
      cyc(30);
      chk(first_own == 2'b01, $sformatf("R6 local first sel=%0d", s), first_own, 1);
      chk(loc_n == exp_len(s), "R6 local burst length", loc_n, exp_len(s));
      chk(rmt_n == 5, "R6 remote count preserved", rmt_n, 5);
    end

    // R7 local burst appended to a running remote transfer
    for (int s = 0; s < 4; s++) begin
      int trans, held, gaps, f, l;
      burst_sel = 2'(s);
      clr_cnt();
      log_i = 0; log_en = 1'b1;
      pulse_rmt(30);
      cyc(5);
      pulse_fifo();
      cyc(55);
      log_en = 1'b0;
      trans = 0; held = 1; gaps = 0; f = -1; l = -1;
      for (int i = 0; i < log_i; i++) begin
        if (own_log[i] != 2'b00) begin
          if (f < 0) f = i;
          l = i;
        end
        if (i + 1 < log_i && own_log[i] == 2'b10 && own_log[i+1] == 2'b01) begin
          trans++;
          if (!(breq_log[i] && breq_log[i+1])) held = 0;
        end
      end
      for (int i = 0; i < log_i; i++)
        if (f >= 0 && i > f && i < l && !breq_log[i]) gaps++;
      chk(trans == 1, $sformatf("R7 direct remote-to-local switch sel=%0d", s), trans, 1);
      chk(held == 1, "R7 bus held across append", held, 1);
      chk(gaps == 1, "R7 one released cycle before remote resumes", gaps, 1);
      chk(loc_n == exp_len(s) && rmt_n == 30, "R7 byte totals", loc_n * 1000 + rmt_n,
          exp_len(s) * 1000 + 30);
    end

    // R8 abort sources during a remote transfer
    for (int k = 0; k < 5; k++) begin
      pulse_rmt(40);
      cyc(6);
      @(negedge clk); set_abort(k, 1'b1); #1;
      chk(byte_strobe == 1'b0 && bus_req == 1'b0, $sformatf("R8 gated same cycle src=%0d", k),
          byte_strobe, 0);
      @(negedge clk); set_abort(k, 1'b0); #1;
      chk(in_reset == 1'b1, $sformatf("R8 reset entered src=%0d", k), in_reset, 1);
      clr_cnt();
      start_cmd();
      cyc(50);
      chk(rmt_n == 0 && loc_n == 0, $sformatf("R8 pending count discarded src=%0d", k), rmt_n, 0);
    end

    // R8 abort during a local burst
    burst_sel = 2'd3;
    clr_cnt();
    pulse_fifo();
    cyc(3);
    @(negedge clk); err_fifo_over = 1'b1; #1;
    chk(byte_strobe == 1'b0 && bus_req == 1'b0, "R8 local burst cut", byte_strobe, 0);
    @(negedge clk); err_fifo_over = 1'b0; #1;
    chk(in_reset == 1'b1 && loc_n < 12, "R8 reset during local burst", loc_n, 3);

    // R9 owner encoding and strobe ownership over the whole run
    chk(viol_n == 0, "R9 owner encoding violations", viol_n, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule